// File: doc/BRIEF.md
# Two-Read One-Write Register Bank

This block is a small bank of general-purpose registers of the kind that sits beside an execution unit. It has 32 entries of 32 bits. Two read ports, A and B, each take an entry number and present that entry's contents without waiting for a clock edge. A single write port takes an entry number, a data word and an enable, and commits the word on the rising edge of the clock.

Entry zero is a constant: it always reads as all zeros, and any write aimed at it is dropped. The other entries have no reset. Their contents are undefined until they are first written, so a user writes every entry it relies on before reading it. Writes are not forwarded to the read ports. A read of the entry being written in the same cycle returns the stored word until the edge. All ports are plain signals with no handshake, because a read or a write finishes within one cycle and cannot be held back.

Top module: `regfile3p`

## Requirements
- R1: The bank holds 32 entries of 32 bits, selected by 5-bit binary entry numbers 0 to 31. A word written to entry n is later read back unchanged from entry n.
- R2: Read ports A and B are independent. Each returns the entry named by its own address, whatever the other port selects.
- R3: When `wr_en` is 1 at a rising edge of `clk` and `wr_addr` is not 0, the entry `wr_addr` takes `wr_data` at that edge. From then on, a read of that entry returns `wr_data`.
- R4: When `wr_en` is 0 at a rising edge, no entry changes, whatever `wr_addr` and `wr_data` hold.
- R5: A read of entry 0 on either port returns 0 at all times, including before any write.
- R6: A write with `wr_en` = 1 and `wr_addr` = 0 changes no entry, and entry 0 still reads 0 afterwards.
- R7: The read outputs are combinational. A change of a read address, or a committed write, shows on the read data within the same cycle, with no clock delay.
- R8: When a read address equals `wr_addr` while a write is pending, that read returns the previously stored word until the rising edge. There is no forwarding.
- R9: When both read ports select the same entry, they return identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Writes commit on its rising edge |
| rd_addr_a | input | 5 | Entry number read by port A |
| rd_data_a | output | 32 | Contents of the entry chosen by `rd_addr_a` |
| rd_addr_b | input | 5 | Entry number read by port B |
| rd_data_b | output | 32 | Contents of the entry chosen by `rd_addr_b` |
| wr_addr | input | 5 | Entry number to write |
| wr_data | input | 32 | Word to write |
| wr_en | input | 1 | Write enable, sampled at the rising edge |

## Verification
A read and a write can target the same entry in the same cycle. The bench provokes this both with directed cycles and with random traffic that often draws the same small address for a read port and the write port. In the low half of the clock it checks that the read port still shows the old word, and just after the edge it checks that the same port shows the new word. A write to entry 0 paired with a read of entry 0 is also driven, and the read must stay zero on both sides of the edge.

// File: rtl/regfile3p_pkg.sv
package regfile3p_pkg;
  // Default geometry of the bank
  localparam int unsigned RF_DEF_ENTRIES = 32;
  localparam int unsigned RF_DEF_WIDTH   = 32;
  // Number of read ports built by the top module
  localparam int unsigned RF_READ_PORTS  = 2;

  // Entry-number width for a given entry count (at least one bit)
  function automatic int unsigned rf_addr_bits(input int unsigned entries);
    return (entries > 1) ? $clog2(entries) : 1;
  endfunction
endpackage

// File: rtl/rf_write_decode.sv
// Turns the write address and enable into one enable line per entry.
// Entry 0 never receives an enable.
module rf_write_decode #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned AW      = 5
) (
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  output logic [ENTRIES-1:0] row_we
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    if (g == 0) begin : g_fixed
      assign row_we[g] = 1'b0;
    end else begin : g_live
      assign row_we[g] = wr_en && (wr_addr == AW'(g));
    end
  end
endmodule

// File: rtl/rf_storage.sv
// Holds the entries. Entry 0 is a constant zero and has no flops.
module rf_storage #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned WIDTH   = 32
) (
  input  logic                          clk,
  input  logic [ENTRIES-1:0]            row_we,
  input  logic [WIDTH-1:0]              wr_data,
  output logic [ENTRIES-1:0][WIDTH-1:0] rows
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign rows[g] = '0;
    end else begin : g_reg
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk) begin
        if (row_we[g]) begin
          q <= wr_data;
        end
      end
      assign rows[g] = q;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
// One combinational read port: picks an entry by number.
// Numbers beyond the entry count read as zero.
module rf_read_port #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned AW      = 5
) (
  input  logic [ENTRIES-1:0][WIDTH-1:0] rows,
  input  logic [AW-1:0]                 rd_addr,
  output logic [WIDTH-1:0]              rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < int'(ENTRIES); i++) begin
      if (rd_addr == AW'(i)) begin
        rd_data = rows[i];
      end
    end
  end
endmodule

// File: rtl/regfile3p.sv
module regfile3p
  import regfile3p_pkg::*;
#(
  parameter int unsigned ENTRIES = RF_DEF_ENTRIES,
  parameter int unsigned WIDTH   = RF_DEF_WIDTH,
  localparam int unsigned AW     = rf_addr_bits(ENTRIES)
) (
  input  logic             clk,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_en
);
  localparam int unsigned NRD = RF_READ_PORTS;

  logic [ENTRIES-1:0]            row_we;
  logic [ENTRIES-1:0][WIDTH-1:0] rows;
  logic [NRD-1:0][AW-1:0]        rd_addr_v;
  logic [NRD-1:0][WIDTH-1:0]     rd_data_v;

  rf_write_decode #(.ENTRIES(ENTRIES), .AW(AW)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .row_we  (row_we)
  );

  rf_storage #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .row_we  (row_we),
    .wr_data (wr_data),
    .rows    (rows)
  );

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    rf_read_port #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_rd (
      .rows    (rows),
      .rd_addr (rd_addr_v[p]),
      .rd_data (rd_data_v[p])
    );
  end

  assign rd_data_a = rd_data_v[0];
  assign rd_data_b = rd_data_v[1];
endmodule

// File: rtl/regfile3p_checker.sv
module regfile3p_checker #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AW    = 5
) (
  input logic             clk,
  input logic [AW-1:0]    rd_addr_a,
  input logic [WIDTH-1:0] rd_data_a,
  input logic [AW-1:0]    rd_addr_b,
  input logic [WIDTH-1:0] rd_data_b,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic             wr_en
);
  // The bank has no reset: properties start after the first two edges
  logic [1:0] armed = 2'b00;
  always_ff @(posedge clk) armed <= {armed[0], 1'b1};
  logic live;
  assign live = armed[1];

  assert_zero_entry_a_R5: assert property (@(posedge clk) disable iff (!live)
    (rd_addr_a == '0) |-> (rd_data_a == '0));
  assert_zero_entry_b_R5: assert property (@(posedge clk) disable iff (!live)
    (rd_addr_b == '0) |-> (rd_data_b == '0));

  assert_same_entry_R9: assert property (@(posedge clk) disable iff (!live)
    (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

  // A commit is visible on the next cycle if port A keeps pointing at it
  assert_commit_seen_R3: assert property (@(posedge clk) disable iff (!live)
    (wr_en && wr_addr != '0) |=>
      (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

  // An entry not being written keeps its word across the edge
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!live)
    (!wr_en || wr_addr != rd_addr_a || wr_addr == '0) |=>
      (rd_addr_a != $past(rd_addr_a) || rd_data_a == $past(rd_data_a)));

  assert_zero_write_dropped_R6: assert property (@(posedge clk) disable iff (!live)
    (wr_en && wr_addr == '0) |=> (rd_addr_b != '0 || rd_data_b == '0));
endmodule

bind regfile3p regfile3p_checker #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk       (clk),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_en     (wr_en)
);

// File: tb/regfile3p_tb.sv
`timescale 1ns/1ps
module regfile3p_tb;
  localparam int W  = 32;
  localparam int D  = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [W-1:0]  rd_data_a, rd_data_b, wr_data = '0;
  logic          wr_en = 1'b0;

  regfile3p u_dut (
    .clk(clk), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en)
  );

  logic [W-1:0] model [D];
  bit           known [D];
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  function automatic logic [W-1:0] exp_read(input logic [AW-1:0] a);
    return (a == '0) ? '0 : model[a];
  endfunction

  function automatic bit can_check(input logic [AW-1:0] a);
    return (a == '0) || known[a];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle in the low phase, check reads before the edge, commit the model at the edge
  task automatic cycle(input bit we, input logic [AW-1:0] wa, input logic [W-1:0] wd,
                       input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string req);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    #1;
    if (can_check(ra)) chk(req, rd_data_a, exp_read(ra));
    if (can_check(rb)) chk(req, rd_data_b, exp_read(rb));
    @(posedge clk);
    if (we && wa != '0) begin
      model[wa] = wd;
      known[wa] = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < D; i++) begin model[i] = '0; known[i] = 1'b0; end

    // R5: entry zero before any write
    #1;
    chk("R5", rd_data_a, '0);
    chk("R5", rd_data_b, '0);

    // R1/R3: fill every entry, port B reads the one written last
    for (int i = 1; i < D; i++)
      cycle(1'b1, AW'(i), $urandom(), AW'(0), AW'(i - 1), "R1");

    // R1/R2: read back on both ports, opposite orders
    for (int i = 0; i < D; i++)
      cycle(1'b0, '0, '0, AW'(i), AW'(D - 1 - i), "R2");

    // R6: write to entry zero dropped
    cycle(1'b1, '0, 32'hDEAD_BEEF, '0, '0, "R6");
    cycle(1'b0, '0, '0, '0, '0, "R6");

    // R8 then R3: write entry 7 while port A reads it
    cycle(1'b1, AW'(7), 32'hA5A5_0F0F, AW'(7), AW'(7), "R8");
    #1;
    chk("R3", rd_data_a, 32'hA5A5_0F0F);
    chk("R3", rd_data_b, 32'hA5A5_0F0F);

    // R7: address changes show up with no edge
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 1; i < 6; i++) begin
      rd_addr_a = AW'(i * 5);
      #1;
      chk("R7", rd_data_a, exp_read(AW'(i * 5)));
    end

    // R9: both ports on one entry
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a = AW'($urandom_range(0, D - 1));
      cycle(1'b0, '0, '0, a, a, "R9");
    end

    // R4: enable low with busy address and data, then full readback
    for (int i = 0; i < 16; i++)
      cycle(1'b0, AW'($urandom_range(1, D - 1)), $urandom(), AW'(i), AW'(i + 16), "R4");
    for (int i = 0; i < D; i++)
      cycle(1'b0, '0, '0, AW'(i), AW'(i), "R4");

    // Random mix biased toward colliding addresses
    for (int n = 0; n < 3000; n++) begin
      bit            we = ($urandom_range(0, 3) != 0);
      logic [AW-1:0] wa = AW'($urandom_range(0, 3));
      logic [AW-1:0] ra = ($urandom_range(0, 1) != 0) ? wa : AW'($urandom_range(0, D - 1));
      logic [AW-1:0] rb = AW'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) wa = AW'($urandom_range(0, D - 1));
      cycle(we, wa, $urandom(), ra, rb, "R3");
    end

    cycle(1'b0, '0, '0, '0, '0, "R5");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule